// File: doc/BRIEF.md
# Windowed Mean-Square Accumulator

This block forms the weighted mean square of a window of 2N signed samples that sit in an external ring buffer. The window is made of two segments of N samples each, the left one and the right one. Each segment starts at its own base address. A single table of N unsigned weights holds half of a symmetric raised-cosine window. Entry 0 is the peak and entry N−1 is close to zero. The left segment walks that table from its tail towards its head, and the right segment walks it from its head towards its tail. Every sample is squared, multiplied by its weight and added into a wide unsigned accumulator. The final sum is scaled by 1/N with a fixed-point reciprocal multiply.

Software or an init sequencer writes the weight table once through the coefficient write port. After that, each start strobe runs one full pass without further set-up. The block reads one sample per cycle from a synchronous buffer RAM with one cycle of read latency. It raises a one-cycle valid pulse when the scaled result is ready. The square root is left to the consumer, and so is any offset handling: samples arrive with mid-scale already at code zero.

Top module: `wms_accum`

## Requirements
- R1: Samples are 16-bit two's complement and are squared as signed values, so code −32768 contributes 2^30 times its weight.
- R2: Left-segment sample i, read from address (base_left + i) mod BUF_DEPTH, is multiplied by table entry N−1−i.
- R3: Right-segment sample i, read from address (base_right + i) mod BUF_DEPTH, is multiplied by table entry i.
- R4: With S the 64-bit unsigned sum of sample² × weight over all 2N samples, result equals floor(S × K / 2^32), where K = ceil(2^32 / N).
- R5: Table entries written through the coefficient port stay in force for every later pass until they are rewritten.
- R6: result_valid is a one-cycle pulse that rises 2N+3 clock edges after the edge that accepts start. busy rises on the accepting edge, stays high for 2N+3 cycles, and is low while result_valid is high.
- R7: Buffer addresses wrap modulo BUF_DEPTH, so either segment may straddle the end of the ring.
- R8: A start strobe that arrives while busy is high has no effect. The running pass keeps its bases, and no extra result pulse follows.
- R9: The accumulator is cleared by each accepted start, so a result depends only on the samples of its own window.
- R10: After synchronous reset, busy, result_valid and rd_en are low and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start one pass (taken only when idle) |
| base_left | input | $clog2(BUF_DEPTH) | Ring address of the first left-segment sample |
| base_right | input | $clog2(BUF_DEPTH) | Ring address of the first right-segment sample |
| busy | output | 1 | Pass in progress |
| rd_en | output | 1 | Buffer RAM read enable |
| rd_addr | output | $clog2(BUF_DEPTH) | Buffer RAM read address |
| rd_data | input | SAMP_W | Signed sample, valid one cycle after rd_en |
| coef_we | input | 1 | Weight table write enable |
| coef_addr | input | $clog2(SEG_LEN) | Weight table write address |
| coef_wdata | input | COEF_W | Weight value |
| result | output | ACC_W | Scaled weighted mean square |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that both base addresses presented with an accepted start are below BUF_DEPTH, and that coefficient writes address the table inside its depth. They also assume that the table is not rewritten while a pass is running. The bench keeps every base it drives inside the ring, including bases that sit a few entries from the end. It loads or changes the table only between passes, after result_valid has been seen. The buffer model in the bench returns data one cycle after rd_en, which matches the latency the pipeline is built around.

// File: rtl/wms_pkg.sv
package wms_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;

  // Ceiling of 2^sh / n, used as the fixed-point reciprocal for the 1/N scale.
  function automatic logic [63:0] recip_ceil(input int n, input int sh);
    logic [63:0] one_sh;
    one_sh = 64'd1 << sh;
    return (one_sh + 64'(n) - 64'd1) / 64'(n);
  endfunction

endpackage

// File: rtl/wms_coef_ram.sv
module wms_coef_ram #(
  parameter int DEPTH = 200,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  // Plain write-then-registered-read shape so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // Input assumption: table writes stay inside the table (R5).
  assert_coef_addr_R5: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr <= TOP_ADDR);

endmodule

// File: rtl/wms_seq.sv
module wms_seq
  import wms_pkg::*;
#(
  parameter int SEG_LEN   = 200,
  parameter int BUF_DEPTH = 800,
  parameter int AW        = 10,
  parameter int CAW       = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [AW-1:0]  base_l_i,
  input  logic [AW-1:0]  base_r_i,
  input  logic           fin_i,
  output logic           busy_o,
  output logic           clear_o,
  output logic           rd_en_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic [CAW-1:0] widx_o,
  output logic           last_o
);

  localparam int              IW        = $clog2(2 * SEG_LEN + 1);
  localparam logic [IW-1:0]   TWO_N     = IW'(2 * SEG_LEN);
  localparam logic [IW-1:0]   LAST_IDX  = IW'(2 * SEG_LEN - 1);
  localparam logic [IW-1:0]   HALF      = IW'(SEG_LEN);
  localparam logic [AW-1:0]   LAST_ADDR = AW'(BUF_DEPTH - 1);
  localparam logic [CAW-1:0]  W_TOP     = CAW'(SEG_LEN - 1);

  seq_state_t    state_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_r_q;
  logic          accept;
  logic [AW-1:0] addr_inc;

  assign accept   = start_i && (state_q == SEQ_IDLE);
  assign clear_o  = accept;
  assign busy_o   = (state_q != SEQ_IDLE);
  assign addr_inc = (rd_addr_o == LAST_ADDR) ? '0 : rd_addr_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      idx_q     <= '0;
      base_r_q  <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      widx_o    <= '0;
      last_o    <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          rd_en_o <= 1'b0;
          last_o  <= 1'b0;
          if (accept) begin
            base_r_q  <= base_r_i;
            rd_addr_o <= base_l_i;
            widx_o    <= W_TOP;
            rd_en_o   <= 1'b1;
            idx_q     <= IW'(1);
            state_q   <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (idx_q == TWO_N) begin
            rd_en_o <= 1'b0;
            last_o  <= 1'b0;
            state_q <= SEQ_DRAIN;
          end else begin
            rd_en_o <= 1'b1;
            last_o  <= (idx_q == LAST_IDX);
            idx_q   <= idx_q + 1'b1;
            if (idx_q == HALF) begin
              rd_addr_o <= base_r_q;
              widx_o    <= '0;
            end else if (idx_q < HALF) begin
              rd_addr_o <= addr_inc;
              widx_o    <= widx_o - 1'b1;
            end else begin
              rd_addr_o <= addr_inc;
              widx_o    <= widx_o + 1'b1;
            end
          end
        end
        SEQ_DRAIN: begin
          if (fin_i) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Input assumption: bases handed over with an accepted start lie in the ring.
  assert_base_in_ring_R7: assert property (@(posedge clk) disable iff (rst)
    accept |-> (base_l_i <= LAST_ADDR) && (base_r_i <= LAST_ADDR));

  assert_addr_wraps_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> rd_addr_o <= LAST_ADDR);

  assert_widx_range_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> widx_o <= W_TOP);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(base_r_q));

  assert_last_once_R6: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !last_o);

endmodule

// File: rtl/wms_mac.sv
module wms_mac #(
  parameter int          SAMP_W      = 16,
  parameter int          COEF_W      = 8,
  parameter int          ACC_W       = 64,
  parameter int          SCALE_SHIFT = 32,
  parameter logic [63:0] RECIP       = 64'd21474837
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_i,
  input  logic                     issue_v_i,
  input  logic                     issue_last_i,
  input  logic signed [SAMP_W-1:0] sample_i,
  input  logic [COEF_W-1:0]        coef_i,
  output logic                     fin_o,
  output logic [ACC_W-1:0]         result_o,
  output logic                     result_valid_o
);

  localparam int SQ_W  = 2 * SAMP_W;
  localparam int PR_W  = SQ_W + COEF_W;
  localparam int RC_W  = SCALE_SHIFT + 1;
  localparam int WD_W  = ACC_W + RC_W;
  localparam logic [RC_W-1:0] RECIP_K = RC_W'(RECIP);

  logic                   v1_q, last1_q;
  logic                   v2_q, last2_q;
  logic signed [SQ_W-1:0] sq_s;
  logic [PR_W-1:0]        term;
  logic [PR_W-1:0]        prod_q;
  logic [ACC_W-1:0]       acc_q;
  logic [WD_W-1:0]        wide;
  logic [WD_W-1:0]        shifted;

  // Square in signed arithmetic, then weight the non-negative square.
  assign sq_s    = SQ_W'(sample_i) * SQ_W'(sample_i);
  assign term    = PR_W'($unsigned(sq_s)) * PR_W'(coef_i);
  assign wide    = WD_W'(acc_q) * WD_W'(RECIP_K);
  assign shifted = wide >> SCALE_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0; last1_q <= 1'b0;
      v2_q <= 1'b0; last2_q <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
      fin_o  <= 1'b0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      // Stage 1: sample and weight come back from their RAMs.
      v1_q    <= issue_v_i;
      last1_q <= issue_v_i && issue_last_i;
      // Stage 2: weighted square.
      v2_q    <= v1_q;
      last2_q <= last1_q;
      if (v1_q) prod_q <= term;
      // Stage 3: accumulate.
      if (clear_i)   acc_q <= '0;
      else if (v2_q) acc_q <= acc_q + ACC_W'(prod_q);
      fin_o <= last2_q;
      // Stage 4: scale by 1/N.
      result_valid_o <= fin_o;
      if (fin_o) result_o <= shifted[ACC_W-1:0];
    end
  end

  assert_acc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> acc_q == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (v2_q && !clear_i) |=> acc_q >= $past(acc_q));

  assert_scale_fits_R4: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> shifted[WD_W-1:ACC_W] == '0);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  assert_valid_after_fin_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> $past(fin_o));

endmodule

// File: rtl/wms_accum.sv
module wms_accum
  import wms_pkg::*;
#(
  parameter int SEG_LEN     = 200,
  parameter int BUF_DEPTH   = 800,
  parameter int SAMP_W      = 16,
  parameter int COEF_W      = 8,
  parameter int ACC_W       = 64,
  parameter int SCALE_SHIFT = 32,
  localparam int AW  = $clog2(BUF_DEPTH),
  localparam int CAW = $clog2(SEG_LEN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [AW-1:0]            base_left,
  input  logic [AW-1:0]            base_right,
  output logic                     busy,
  output logic                     rd_en,
  output logic [AW-1:0]            rd_addr,
  input  logic signed [SAMP_W-1:0] rd_data,
  input  logic                     coef_we,
  input  logic [CAW-1:0]           coef_addr,
  input  logic [COEF_W-1:0]        coef_wdata,
  output logic [ACC_W-1:0]         result,
  output logic                     result_valid
);

  localparam logic [63:0] RECIP = recip_ceil(SEG_LEN, SCALE_SHIFT);

  logic             clear;
  logic             fin;
  logic             issue_last;
  logic [CAW-1:0]   widx;
  logic [COEF_W-1:0] coef_q;

  wms_coef_ram #(
    .DEPTH (SEG_LEN),
    .AW    (CAW),
    .DW    (COEF_W)
  ) u_table (
    .clk   (clk),
    .rst   (rst),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .raddr (widx),
    .rdata (coef_q)
  );

  wms_seq #(
    .SEG_LEN   (SEG_LEN),
    .BUF_DEPTH (BUF_DEPTH),
    .AW        (AW),
    .CAW       (CAW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .base_l_i  (base_left),
    .base_r_i  (base_right),
    .fin_i     (fin),
    .busy_o    (busy),
    .clear_o   (clear),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .widx_o    (widx),
    .last_o    (issue_last)
  );

  wms_mac #(
    .SAMP_W      (SAMP_W),
    .COEF_W      (COEF_W),
    .ACC_W       (ACC_W),
    .SCALE_SHIFT (SCALE_SHIFT),
    .RECIP       (RECIP)
  ) u_mac (
    .clk            (clk),
    .rst            (rst),
    .clear_i        (clear),
    .issue_v_i      (rd_en),
    .issue_last_i   (issue_last),
    .sample_i       (rd_data),
    .coef_i         (coef_q),
    .fin_o          (fin),
    .result_o       (result),
    .result_valid_o (result_valid)
  );

  assert_idle_at_result_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

  assert_read_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

endmodule

// File: tb/tb_wms_accum.sv
module tb_wms_accum;

  localparam int N     = 8;
  localparam int DEPTH = 24;
  localparam int AW    = $clog2(DEPTH);
  localparam int CAW   = $clog2(N);
  localparam int LAT   = 2 * N + 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [AW-1:0]     base_left = '0, base_right = '0;
  logic              busy, rd_en, result_valid;
  logic [AW-1:0]     rd_addr;
  logic signed [15:0] rd_data;
  logic              coef_we = 1'b0;
  logic [CAW-1:0]    coef_addr = '0;
  logic [7:0]        coef_wdata = '0;
  logic [63:0]       result;

  logic signed [15:0] buf_mem [DEPTH];
  logic [7:0]         tbl [N];

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= buf_mem[rd_addr];

  wms_accum #(.SEG_LEN(N), .BUF_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .start(start), .base_left(base_left),
    .base_right(base_right), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .result(result), .result_valid(result_valid));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int bl, input int br);
    logic [63:0]  s;
    logic [127:0] p;
    logic [63:0]  k;
    longint       v;
    s = 0;
    for (int i = 0; i < N; i++) begin
      v = longint'(buf_mem[(bl + i) % DEPTH]);
      s += 64'(v * v) * 64'(tbl[N - 1 - i]);
      v = longint'(buf_mem[(br + i) % DEPTH]);
      s += 64'(v * v) * 64'(tbl[i]);
    end
    k = ((64'd1 << 32) + 64'(N) - 1) / 64'(N);
    p = 128'(s) * 128'(k);
    return p[95:32];
  endfunction

  task automatic write_tbl(input int mode);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (mode == 0)
        tbl[i] = 8'($rtoi(255.0 * (0.5 + 0.5 * $cos(3.141592653589793 * i / (N - 1))) + 0.5));
      else if (mode == 1) tbl[i] = 8'(10 + 30 * i);
      else                tbl[i] = 8'd255;
      coef_we = 1'b1; coef_addr = CAW'(i); coef_wdata = tbl[i];
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // Runs one pass; optionally fires a second start 5 cycles in (R8).
  task automatic run_pass(input int bl, input int br, input bit poke,
                          output logic [63:0] res, output int lat,
                          output int busy_cnt, output int extra_pulses);
    int n = 0;
    busy_cnt = 0; extra_pulses = 0; lat = -1; res = '0;
    @(negedge clk);
    start = 1'b1; base_left = AW'(bl); base_right = AW'(br);
    @(negedge clk);
    start = 1'b0;
    while (n < 4 * N + 40) begin
      if (result_valid) begin lat = n; res = result; break; end
      if (busy) busy_cnt++;
      if (poke && n == 5) begin
        start = 1'b1; base_left = AW'((bl + 7) % DEPTH); base_right = AW'((br + 3) % DEPTH);
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (lat < 0) chk(1'b0, "watchdog R6", 64'(n), 64'(LAT));
    if (lat >= 0) begin
      chk(!busy, "R6 busy low with valid", 64'(busy), 64'd0);
      for (int j = 0; j < LAT + 4; j++) begin
        @(negedge clk);
        if (result_valid) extra_pulses++;
      end
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < DEPTH; i++) buf_mem[i] = 16'(i * 7919 + seed * 4099 - 30000);
  endtask

  task automatic t_reset();
    chk(!busy, "R10 busy", 64'(busy), 0);
    chk(!result_valid, "R10 valid", 64'(result_valid), 0);
    chk(!rd_en, "R10 rd_en", 64'(rd_en), 0);
    chk(result == 0, "R10 result", result, 0);
  endtask

  task automatic t_basic();
    logic [63:0] r; int lat, bc, ex;
    write_tbl(0); fill(1);
    run_pass(0, N, 1'b0, r, lat, bc, ex);
    chk(r == model(0, N), "R4 hann window", r, model(0, N));
    chk(lat == LAT, "R6 latency", 64'(lat), 64'(LAT));
    chk(bc == LAT, "R6 busy length", 64'(bc), 64'(LAT));
    chk(ex == 0, "R6 single pulse", 64'(ex), 0);
  endtask

  task automatic t_order();
    logic [63:0] r; int lat, bc, ex;
    write_tbl(1);
    for (int i = 0; i < DEPTH; i++) buf_mem[i] = 16'sd0;
    buf_mem[0] = 16'sd100;                 // left segment, i = 0
    run_pass(0, N, 1'b0, r, lat, bc, ex);
    chk(r == model(0, N), "R2 left reversed", r, model(0, N));
    buf_mem[0] = 16'sd0; buf_mem[N + 2] = -16'sd300;   // right segment, i = 2
    run_pass(0, N, 1'b0, r, lat, bc, ex);
    chk(r == model(0, N), "R3 right forward", r, model(0, N));
  endtask

  task automatic t_extreme();
    logic [63:0] r; int lat, bc, ex;
    write_tbl(2);
    for (int i = 0; i < DEPTH; i++) buf_mem[i] = (i % 2) ? 16'sh8000 : 16'sh7fff;
    run_pass(2, 2 + N, 1'b0, r, lat, bc, ex);
    chk(r == model(2, 2 + N), "R1 full scale", r, model(2, 2 + N));
  endtask

  task automatic t_wrap();
    logic [63:0] r; int lat, bc, ex;
    write_tbl(1); fill(3);
    run_pass(DEPTH - 3, DEPTH - 5, 1'b0, r, lat, bc, ex);
    chk(r == model(DEPTH - 3, DEPTH - 5), "R7 wrap", r, model(DEPTH - 3, DEPTH - 5));
  endtask

  task automatic t_busy_start();
    logic [63:0] r; int lat, bc, ex;
    fill(5);
    run_pass(4, 12, 1'b1, r, lat, bc, ex);
    chk(r == model(4, 12), "R8 bases kept", r, model(4, 12));
    chk(lat == LAT, "R8 latency kept", 64'(lat), 64'(LAT));
    chk(ex == 0, "R8 no extra pulse", 64'(ex), 0);
  endtask

  task automatic t_reuse();
    logic [63:0] r; int lat, bc, ex;
    fill(9);
    run_pass(1, 9, 1'b0, r, lat, bc, ex);
    fill(11);
    run_pass(1, 9, 1'b0, r, lat, bc, ex);
    chk(r == model(1, 9), "R9 R5 fresh window same table", r, model(1, 9));
    for (int i = 0; i < DEPTH; i++) buf_mem[i] = 16'sd0;
    run_pass(1, 9, 1'b0, r, lat, bc, ex);
    chk(r == 0, "R9 zero window", r, 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) buf_mem[i] = '0;
    for (int i = 0; i < N; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_extreme();
    t_wrap();
    t_busy_start();
    t_reuse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule